// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two two's complement integers and returns their full signed product, with the multiplicand WA bits wide, the multiplier WB bits wide and the product WA+WB bits wide. The product logic is combinational. It rewrites the multiplier as one signed digit per bit position, and each digit is -1, 0 or +1. A run of consecutive ones therefore costs one addition at the top of the run and one subtraction at the bottom. For example, a multiplier of 30 (binary 011110) turns into +32 and -2.

Each digit picks one partial-product row: zero, the multiplicand, or the inverted multiplicand. The row is sign-extended to the full product width and shifted left by the digit's position. When the digit is -1, a single +1 is added at that row's lowest position, so inversion plus this bit gives the two's complement negation. One adder sums all rows and all correction bits.

The sum is captured in an output register whenever the input strobe is high. The output strobe rises one clock after the input strobe.

Top module: `booth_r2_mult`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `product` holds the exact signed product of the `mcand` and `mplier` sampled in that cycle, as a WA+WB-bit two's complement value, for every pair of operand values.
- R2: Digit i of the multiplier is bit i-1 minus bit i, and bit -1 is taken as 0. A run of ones such as 30 (011110) therefore gives the exact product, and across all digits the count of -1 digits minus the count of +1 digits equals the multiplier's sign bit.
- R3: An all-ones multiplicand times an all-ones multiplier (-1 × -1) gives +1. It does not give the unsigned result (255 × 255 at 8 bits).
- R4: The most negative multiplicand times -1 gives +2^(WA-1), a positive value in the full-width product, with no wrap.
- R5: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was high.
- R6: While `in_valid` is low, `product` keeps its last value whatever the operand inputs do.
- R7: While `rst_n` is low, `out_valid` is 0 and `product` is 0, even when `in_valid` is high.
- R8: A zero multiplier gives a zero product for any multiplicand, because every digit is zero.
- R9: The most negative multiplicand times the most negative multiplier gives +2^(WA+WB-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: operands are valid and the product register loads |
| mcand | input | WA | Multiplicand, two's complement |
| mplier | input | WB | Multiplier, two's complement; this operand is recoded |
| out_valid | output | 1 | Registered strobe; `product` holds a fresh result |
| product | output | WA+WB | Registered signed product |

## Verification
The cases hardest to reach are those in which a -1 digit meets a negative multiplicand. There the inverted row, its injected +1 and the sign extension must all combine to give a positive value, and the extreme case is the most negative multiplicand times -1. A vector table places those points and alternating-bit and run-of-ones multipliers in front. An exhaustive sweep of all 65,536 operand pairs at the default widths, one pair per clock, then covers every digit pattern and every sign mix. Directed steps hold the strobe high during reset and change the operands while the strobe is low, to show that the register ignores them.

// File: rtl/booth_r2_pkg.sv
package booth_r2_pkg;

  // One recoded digit: nz = digit is non-zero, neg = digit is -1.
  typedef struct packed {
    logic nz;
    logic neg;
  } booth_digit_t;

  // Digit value = lower bit minus current bit.
  function automatic booth_digit_t recode_pair(input logic lower_bit, input logic cur_bit);
    booth_digit_t d;
    d.nz  = lower_bit ^ cur_bit;
    d.neg = cur_bit & ~lower_bit;
    return d;
  endfunction

endpackage

// File: rtl/booth_digit_recoder.sv
module booth_digit_recoder
  import booth_r2_pkg::*;
#(
  parameter int WB = 8
) (
  input  logic [WB-1:0] mplier,
  output logic [WB-1:0] dig_nz,
  output logic [WB-1:0] dig_neg
);

  // Multiplier extended with an implied zero below bit 0.
  logic [WB:0] scan_bits;
  assign scan_bits = {mplier, 1'b0};

  for (genvar g = 0; g < WB; g++) begin : g_digit
    booth_digit_t d;
    assign d          = recode_pair(scan_bits[g], scan_bits[g+1]);
    assign dig_nz[g]  = d.nz;
    assign dig_neg[g] = d.neg;
  end

endmodule

// File: rtl/booth_row_select.sv
module booth_row_select #(
  parameter int WA  = 8,
  parameter int PW  = 16,
  parameter int ROW = 0
) (
  input  logic [WA-1:0] mcand,
  input  logic          nz,
  input  logic          neg,
  output logic [PW-1:0] row,
  output logic          corr
);

  localparam int EXT = PW - WA;

  // Sign-extend the multiplicand to the full product width.
  function automatic logic [PW-1:0] sext(input logic [WA-1:0] v);
    return {{EXT{v[WA-1]}}, v};
  endfunction

  logic [PW-1:0] ext_val;
  logic [PW-1:0] sel_val;

  assign ext_val = sext(mcand);
  assign sel_val = neg ? ~ext_val : ext_val;
  assign row     = nz ? (sel_val << ROW) : '0;
  // The +1 that completes the negation, weighted at this row's lowest position.
  assign corr    = nz & neg;

endmodule

// File: rtl/booth_row_adder.sv
module booth_row_adder #(
  parameter int PW   = 16,
  parameter int ROWS = 8
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  input  logic [PW-1:0]           corr_vec,
  output logic [PW-1:0]           sum
);

  function automatic logic [PW-1:0] add_rows(input logic [ROWS-1:0][PW-1:0] r,
                                             input logic [PW-1:0] c);
    logic [PW-1:0] acc;
    acc = c;
    for (int i = 0; i < ROWS; i++) begin
      acc = acc + r[i];
    end
    return acc;
  endfunction

  assign sum = add_rows(rows, corr_vec);

endmodule

// File: rtl/booth_r2_mult.sv
module booth_r2_mult #(
  parameter int WA = 8,
  parameter int WB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WA-1:0]    mcand,
  input  logic [WB-1:0]    mplier,
  output logic             out_valid,
  output logic [WA+WB-1:0] product
);

  localparam int PW = WA + WB;

  // Named internal events for the checker.
  logic [WB-1:0]          dig_nz;
  logic [WB-1:0]          dig_neg;
  logic [WB-1:0][PW-1:0]  rows;
  logic [WB-1:0]          corr_bits;
  logic [PW-1:0]          corr_vec;
  logic [PW-1:0]          sum_comb;

  booth_digit_recoder #(.WB(WB)) recoder_i (
    .mplier  (mplier),
    .dig_nz  (dig_nz),
    .dig_neg (dig_neg)
  );

  for (genvar g = 0; g < WB; g++) begin : g_row
    booth_row_select #(.WA(WA), .PW(PW), .ROW(g)) sel_i (
      .mcand (mcand),
      .nz    (dig_nz[g]),
      .neg   (dig_neg[g]),
      .row   (rows[g]),
      .corr  (corr_bits[g])
    );
  end

  assign corr_vec = {{(PW-WB){1'b0}}, corr_bits};

  booth_row_adder #(.PW(PW), .ROWS(WB)) adder_i (
    .rows     (rows),
    .corr_vec (corr_vec),
    .sum      (sum_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product <= sum_comb;
      end
    end
  end

endmodule

// File: rtl/booth_r2_mult_chk.sv
module booth_r2_mult_chk #(
  parameter int WA = 8,
  parameter int WB = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WA-1:0]    mcand,
  input logic [WB-1:0]    mplier,
  input logic             out_valid,
  input logic [WA+WB-1:0] product,
  input logic [WB-1:0]    dig_nz,
  input logic [WB-1:0]    dig_neg
);

  localparam int PW = WA + WB;

  logic signed [PW-1:0] ref_now;
  assign ref_now = $signed(mcand) * $signed(mplier);

  // R1: registered product equals the signed reference of the sampled operands.
  assert_product_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product == $past(ref_now)));

  // R2: telescoping digit sum: count(-1) - count(+1) equals the multiplier sign bit.
  assert_digit_balance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dig_neg) - $countones(dig_nz & ~dig_neg)) == int'(mplier[WB-1]));

  // R2: a digit marked negative is also marked non-zero.
  assert_digit_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_neg & ~dig_nz) == '0);

  // R5: strobe follows one cycle later.
  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6: product holds while the strobe is low.
  assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  // R8: a zero multiplier yields no non-zero digit.
  assert_zero_digits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mplier == '0) |-> (dig_nz == '0));

endmodule

bind booth_r2_mult booth_r2_mult_chk #(.WA(WA), .WB(WB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mcand     (mcand),
  .mplier    (mplier),
  .out_valid (out_valid),
  .product   (product),
  .dig_nz    (dig_nz),
  .dig_neg   (dig_neg)
);

// File: tb/booth_r2_mult_tb_top.sv
`timescale 1ns/1ps
module booth_r2_mult_tb_top;

  localparam int WA = 8;
  localparam int WB = 8;
  localparam int PW = WA + WB;
  localparam int NV = 13;

  // {mcand, mplier, expected product}
  localparam logic [31:0] VEC [NV] = '{
    {8'h0D, 8'h0B, 16'h008F},  // 13*11 = 143            R1
    {8'hFF, 8'hFF, 16'h0001},  // -1*-1 = 1              R3
    {8'h80, 8'hFF, 16'h0080},  // -128*-1 = 128          R4
    {8'h80, 8'h80, 16'h4000},  // -128*-128 = 16384      R9
    {8'h7F, 8'h7F, 16'h3F01},  // 127*127                R1
    {8'h80, 8'h7F, 16'hC080},  // -128*127               R1
    {8'h05, 8'h1E, 16'h0096},  // 5*30 run of ones       R2
    {8'hFD, 8'h1E, 16'hFFA6},  // -3*30                  R2
    {8'h64, 8'h00, 16'h0000},  // 100*0                  R8
    {8'h80, 8'h00, 16'h0000},  // -128*0                 R8
    {8'h07, 8'hFF, 16'hFFF9},  // 7*-1                   R1
    {8'hFE, 8'h55, 16'hFF56},  // -2*85 alternating      R2
    {8'h12, 8'hAA, 16'hF9F4}   // 18*-86 alternating     R2
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [WA-1:0] mcand = '0;
  logic [WB-1:0] mplier = '0;
  logic          out_valid;
  logic [PW-1:0] product;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  booth_r2_mult #(.WA(WA), .WB(WB)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplier    (mplier),
    .out_valid (out_valid),
    .product   (product)
  );

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    // R7: reset dominates an active strobe.
    in_valid = 1'b1;
    mcand    = 8'd3;
    mplier   = 8'd3;
    repeat (3) @(negedge clk);
    check("R7 product in reset", product, '0);
    check("R7 out_valid in reset", PW'(out_valid), '0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    check("R5 out_valid idle", PW'(out_valid), '0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      mcand    = VEC[i][31:24];
      mplier   = VEC[i][23:16];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R1/R2/R3/R4/R8/R9 vec%0d", i), product, VEC[i][15:0]);
      check("R5 out_valid after strobe", PW'(out_valid), PW'(1));
    end

    // R6: operands change while strobe low; product must hold.
    in_valid = 1'b0;
    mcand    = 8'h33;
    mplier   = 8'h44;
    @(negedge clk);
    check("R6 hold product", product, 16'hF9F4);
    check("R5 out_valid drops", PW'(out_valid), '0);
    mcand = 8'h80;
    @(negedge clk);
    check("R6 hold product again", product, 16'hF9F4);

    // R1: exhaustive sweep, one pair per clock.
    in_valid = 1'b1;
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        mcand  = WA'(a);
        mplier = WB'(b);
        @(negedge clk);
        check("R1 exhaustive", product, PW'(a * b));
      end
    end
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule